// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a serial memory attached to a two-wire bus. It oversamples the clock and data lines with a fast system clock and finds the bus start and stop conditions. It receives a device address byte, compares it with a fixed prefix and three strap inputs, and acknowledges by driving an open-drain pull-down enable for the data line. It then sequences the rest of the transfer. In a write, two word-address bytes are followed by any number of data bytes. A read returns data from the current address. A random read is a write header followed by a repeated start and a read. A sequential read keeps going for as long as the master acknowledges.

The engine holds no memory and no address counter. It hands the memory side single-cycle strobes. One loads a new word address, one writes a data byte, one requests the next read byte, and one marks a stop condition. The memory side returns read bytes on a data input and can hold off new transfers with a busy input.

Top module: `tw_mem_slave`

## Requirements
- R1: A start condition (data falls while the clock is high) in any state releases the data line and restarts device-address reception. A stop condition (data rises while the clock is high) in any state releases the data line, returns the engine to idle and pulses stop_o for one cycle.
- R2: The device address byte arrives MSB first. Bits 7:4 must be 1010, bits 3:1 must equal strap_i[2:0], and bit 0 selects read (1) or write (0). On a match the engine pulls the data line low during the ninth clock. On a mismatch it never drives the line and acknowledges no further byte until the next start.
- R3: While busy_i is high when the device address completes, the engine sends no acknowledge, even for a matching address, and raises no strobe.
- R4: After a write device address, two word-address bytes follow, high byte first, and each is acknowledged. When the low byte completes, addr_load_o pulses for one cycle with addr_o equal to the low ADDR_W bits of {high byte, low byte}.
- R5: Each byte after the two address bytes is acknowledged, and wr_stb_o pulses once with wr_data_o equal to that byte. This repeats for any number of bytes until a stop or start.
- R6: A read device address that is acknowledged pulses rd_req_o. The byte on rd_data_i is taken when the ninth clock falls and is shifted out MSB first; a 0 bit pulls the data line low.
- R7: A random read made of a write header with two address bytes, a repeated start and a read device address returns the byte at the loaded address, and it raises no wr_stb_o.
- R8: In a read the engine releases the data line during the ninth clock. A master acknowledge (line low at the ninth rising edge) pulses rd_req_o and starts the next byte. A master no-acknowledge raises no request and leaves the line released until a start or stop.
- R9: The data-line drive changes only in the cycle after a detected clock fall, start or stop. It never changes while the clock is high in a normal transfer.
- R10: After reset the data line is released and no strobe is active. At most one of addr_load_o, wr_stb_o, rd_req_o and stop_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Hard-wired device select straps |
| busy_i | input | 1 | Memory side busy; blocks acknowledge of a new device address |
| rd_data_i | input | 8 | Read byte from the memory side, valid after rd_req_o |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| addr_load_o | output | 1 | One-cycle strobe: load addr_o as the word address |
| addr_o | output | ADDR_W | Word address received in the write header |
| wr_stb_o | output | 1 | One-cycle strobe: write wr_data_o at the current address |
| wr_data_o | output | 8 | Received write byte |
| rd_req_o | output | 1 | One-cycle strobe: present the next read byte |
| stop_o | output | 1 | One-cycle strobe on each stop condition |

## Verification
The acknowledge decision for a device address and a busy memory side meet at one point. When the eighth bit ends, the match test and the busy input are judged in the same cycle. The bench raises busy_i before a matching address and checks that the ninth clock reads back high and that no strobe follows. A start or stop can also arrive in the middle of a byte, when the shifter is still taking bits. The bench cuts a byte after a few bits and checks that the abort wins: no write strobe appears, and the next full address is acknowledged.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;
    localparam int BYTE_W = 8;
    localparam int BCNT_W = 4;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic prv_o
);
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    // Synchronized level and its value one cycle earlier for edge detection
    assign lvl_o = pipe_q[STAGES-1];
    assign prv_o = pipe_q[STAGES];
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
    input  logic scl_lvl_i,
    input  logic scl_prv_i,
    input  logic sda_lvl_i,
    input  logic sda_prv_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_held_high;

    always_comb begin
        scl_held_high = scl_lvl_i & scl_prv_i;
        scl_rise_o    = scl_lvl_i & ~scl_prv_i;
        scl_fall_o    = ~scl_lvl_i & scl_prv_i;
        start_o       = scl_held_high & sda_prv_i & ~sda_lvl_i;
        stop_o        = scl_held_high & ~sda_prv_i & sda_lvl_i;
    end
endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
    import tw_mem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              addr_load_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o,
    output logic              stop_o
);
    // ADDR_W must lie between 9 and 16: the high address byte supplies HI_W bits
    localparam int HI_W = ADDR_W - BYTE_W;
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W);

    typedef struct packed {
        tw_state_e         st;
        logic [BCNT_W-1:0] bcnt;
        logic              in_ack;
        logic              oe;
        logic [BYTE_W-1:0] sh;
        logic [HI_W-1:0]   ahi;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdat;
        logic              addr_ld;
        logic              wr;
        logic              rdreq;
        logic              stop;
    } regs_t;

    regs_t r_d, r_q;
    logic  dev_match;

    always_comb begin
        dev_match = (r_q.sh[7:4] == DEV_PREFIX) && (r_q.sh[3:1] == strap_i) && !busy_i;
    end

    always_comb begin
        r_d         = r_q;
        r_d.addr_ld = 1'b0;
        r_d.wr      = 1'b0;
        r_d.rdreq   = 1'b0;
        r_d.stop    = 1'b0;

        if (stop_i) begin
            r_d.st     = ST_IDLE;
            r_d.oe     = 1'b0;
            r_d.in_ack = 1'b0;
            r_d.bcnt   = '0;
            r_d.stop   = 1'b1;
        end else if (start_i) begin
            r_d.st     = ST_DEV;
            r_d.oe     = 1'b0;
            r_d.in_ack = 1'b0;
            r_d.bcnt   = '0;
        end else if (r_q.st == ST_IDLE) begin
            r_d.oe = 1'b0;
        end else if (r_q.st == ST_RDAT) begin
            // Transmit path: slave shifts out, master answers on the ninth clock
            if (scl_rise_i) begin
                if (r_q.in_ack) begin
                    if (!sda_i) begin
                        r_d.rdreq = 1'b1;
                    end else begin
                        r_d.st     = ST_IDLE;
                        r_d.in_ack = 1'b0;
                    end
                end else if (r_q.bcnt < LAST_BIT) begin
                    r_d.bcnt = r_q.bcnt + 1'b1;
                end
            end else if (scl_fall_i) begin
                if (r_q.in_ack) begin
                    r_d.in_ack = 1'b0;
                    r_d.bcnt   = '0;
                    r_d.sh     = rd_data_i;
                    r_d.oe     = ~rd_data_i[BYTE_W-1];
                end else if (r_q.bcnt == LAST_BIT) begin
                    r_d.oe     = 1'b0;
                    r_d.in_ack = 1'b1;
                end else if (r_q.bcnt != '0) begin
                    r_d.sh = {r_q.sh[BYTE_W-2:0], 1'b0};
                    r_d.oe = ~r_q.sh[BYTE_W-2];
                end
            end
        end else begin
            // Receive path: device address, address bytes, write data
            if (scl_rise_i && !r_q.in_ack && (r_q.bcnt < LAST_BIT)) begin
                r_d.sh   = {r_q.sh[BYTE_W-2:0], sda_i};
                r_d.bcnt = r_q.bcnt + 1'b1;
            end else if (scl_fall_i) begin
                if (r_q.in_ack) begin
                    r_d.in_ack = 1'b0;
                    r_d.bcnt   = '0;
                    r_d.oe     = 1'b0;
                    unique case (r_q.st)
                        ST_DEV: begin
                            if (r_q.sh[0]) begin
                                r_d.st = ST_RDAT;
                                r_d.sh = rd_data_i;
                                r_d.oe = ~rd_data_i[BYTE_W-1];
                            end else begin
                                r_d.st = ST_AHI;
                            end
                        end
                        ST_AHI:  r_d.st = ST_ALO;
                        ST_ALO:  r_d.st = ST_WDAT;
                        default: r_d.st = ST_WDAT;
                    endcase
                end else if (r_q.bcnt == LAST_BIT) begin
                    unique case (r_q.st)
                        ST_DEV: begin
                            if (dev_match) begin
                                r_d.oe     = 1'b1;
                                r_d.in_ack = 1'b1;
                                r_d.rdreq  = r_q.sh[0];
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end
                        ST_AHI: begin
                            r_d.ahi    = r_q.sh[HI_W-1:0];
                            r_d.oe     = 1'b1;
                            r_d.in_ack = 1'b1;
                        end
                        ST_ALO: begin
                            r_d.addr    = {r_q.ahi, r_q.sh};
                            r_d.addr_ld = 1'b1;
                            r_d.oe      = 1'b1;
                            r_d.in_ack  = 1'b1;
                        end
                        default: begin
                            r_d.wdat   = r_q.sh;
                            r_d.wr     = 1'b1;
                            r_d.oe     = 1'b1;
                            r_d.in_ack = 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, bcnt: '0, in_ack: 1'b0, oe: 1'b0, sh: '0,
                     ahi: '0, addr: '0, wdat: '0, addr_ld: 1'b0, wr: 1'b0,
                     rdreq: 1'b0, stop: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o    = r_q.oe;
    assign addr_load_o = r_q.addr_ld;
    assign addr_o      = r_q.addr;
    assign wr_stb_o    = r_q.wr;
    assign wr_data_o   = r_q.wdat;
    assign rd_req_o    = r_q.rdreq;
    assign stop_o      = r_q.stop;

    // R1: a start restarts address reception with the line released
    a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (r_q.st == ST_DEV) && !sda_oe_o && (r_q.bcnt == '0));

    // R1: a stop returns to idle and raises the stop strobe
    a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (r_q.st == ST_IDLE) && stop_o && !sda_oe_o);

    // R2: an acknowledge of a device address needs prefix and strap match
    a_r2_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && ($past(r_q.st) == ST_DEV)) |->
        (($past(r_q.sh[7:4]) == DEV_PREFIX) && ($past(r_q.sh[3:1]) == $past(strap_i))));

    // R3: busy blocks the device address acknowledge
    a_r3_busy_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_DEV) && !r_q.in_ack && busy_i) |=> !$rose(sda_oe_o));

    // R8: a master no-acknowledge ends the read without a request
    a_r8_nack_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_RDAT) && r_q.in_ack && scl_rise_i && sda_i && !start_i && !stop_i)
        |=> (r_q.st == ST_IDLE) && !rd_req_o);

    // R9: the line drive moves only after a clock fall, start or stop
    a_r9_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(scl_fall_i || start_i || stop_i));

    // R10: strobes never overlap
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_load_o, wr_stb_o, rd_req_o, stop_o}));

    // R6: bit counter never passes the ninth position
    a_r6_bcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bcnt <= LAST_BIT);
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
    import tw_mem_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              addr_load_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o,
    output logic              stop_o
);
    logic scl_lvl, scl_prv, sda_lvl, sda_prv;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    tw_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (scl_i),
        .lvl_o  (scl_lvl),
        .prv_o  (scl_prv)
    );

    tw_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (sda_i),
        .lvl_o  (sda_lvl),
        .prv_o  (sda_prv)
    );

    tw_cond_detect u_cond (
        .scl_lvl_i  (scl_lvl),
        .scl_prv_i  (scl_prv),
        .sda_lvl_i  (sda_lvl),
        .sda_prv_i  (sda_prv),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    tw_slave_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (bus_start),
        .stop_i      (bus_stop),
        .sda_i       (sda_lvl),
        .strap_i     (strap_i),
        .busy_i      (busy_i),
        .rd_data_i   (rd_data_i),
        .sda_oe_o    (sda_oe_o),
        .addr_load_o (addr_load_o),
        .addr_o      (addr_o),
        .wr_stb_o    (wr_stb_o),
        .wr_data_o   (wr_data_o),
        .rd_req_o    (rd_req_o),
        .stop_o      (stop_o)
    );
endmodule

// File: tb/tb_tw_mem_slave.sv
module tb_tw_mem_slave;
    localparam int ADDR_W = 13;
    localparam int Q      = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic [2:0]        strap = 3'b000;
    logic              busy  = 1'b0;
    logic [7:0]        rd_data;
    logic              sda_oe, addr_load, wr_stb, rd_req, stop_stb;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wr_data;
    logic              sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    tw_mem_slave #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .strap_i     (strap),
        .busy_i      (busy),
        .rd_data_i   (rd_data),
        .sda_oe_o    (sda_oe),
        .addr_load_o (addr_load),
        .addr_o      (addr),
        .wr_stb_o    (wr_stb),
        .wr_data_o   (wr_data),
        .rd_req_o    (rd_req),
        .stop_o      (stop_stb)
    );

    // Memory-side model and strobe monitor
    logic [7:0]        mem [256];
    logic [7:0]        ptr;
    logic [7:0]        wr_log [16];
    logic [ADDR_W-1:0] last_addr;
    logic              oe_prev;
    int n_ld, n_wr, n_rd, n_stop, n_multi, n_oe_hi;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
            ptr <= 8'h00; rd_data <= 8'h00; last_addr <= '0; oe_prev <= 1'b0;
            n_ld <= 0; n_wr <= 0; n_rd <= 0; n_stop <= 0; n_multi <= 0; n_oe_hi <= 0;
        end else begin
            oe_prev <= sda_oe;
            if (sda_oe != oe_prev && scl_m) n_oe_hi <= n_oe_hi + 1;
            if ((32'(addr_load) + 32'(wr_stb) + 32'(rd_req) + 32'(stop_stb)) > 1)
                n_multi <= n_multi + 1;
            if (addr_load) begin
                ptr <= addr[7:0]; last_addr <= addr; n_ld <= n_ld + 1;
            end
            if (wr_stb) begin
                mem[ptr] <= wr_data; ptr <= ptr + 8'd1;
                wr_log[n_wr % 16] <= wr_data; n_wr <= n_wr + 1;
            end
            if (rd_req) begin
                rd_data <= mem[ptr]; ptr <= ptr + 8'd1; n_rd <= n_rd + 1;
            end
            if (stop_stb) n_stop <= n_stop + 1;
        end
    end

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic clock_bit(input logic b, output logic r);
        sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
        clock_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic r;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, r);
            b = {b[6:0], r};
        end
        clock_bit(~mack, r);
    endtask

    // Device address table: {device byte, strap, expected ack}
    localparam logic [11:0] VEC [8] = '{
        {8'hA0, 3'b000, 1'b1},
        {8'hAA, 3'b101, 1'b1},
        {8'hA6, 3'b011, 1'b1},
        {8'hA6, 3'b010, 1'b0},
        {8'hB0, 3'b000, 1'b0},
        {8'h20, 3'b000, 1'b0},
        {8'hE0, 3'b000, 1'b0},
        {8'hAC, 3'b110, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic       ack;
        logic       r;
        logic [7:0] b;
        int         base;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: reset state
        check(sda_oe == 1'b0, "R10 reset oe", int'(sda_oe), 0);
        check({addr_load, wr_stb, rd_req, stop_stb} == 4'b0000, "R10 reset strobes",
              int'({addr_load, wr_stb, rd_req, stop_stb}), 0);

        // R2: device address table
        foreach (VEC[k]) begin
            strap = VEC[k][3:1];
            bus_start();
            send_byte(VEC[k][11:4], ack);
            check(ack == VEC[k][0], "R2 device address ack", int'(ack), int'(VEC[k][0]));
            bus_stop();
        end

        // R2: after a mismatch the following bytes are ignored
        strap = 3'b000;
        base = n_ld;
        bus_start();
        send_byte(8'hA2, ack);
        check(!ack, "R2 mismatch no ack", int'(ack), 0);
        send_byte(8'h00, ack);
        check(!ack, "R2 ignored byte no ack", int'(ack), 0);
        send_byte(8'h10, ack);
        check(n_ld == base, "R2 ignored no address load", n_ld, base);
        bus_stop();

        // R3: busy blocks acknowledge of a matching address
        busy = 1'b1;
        base = n_ld + n_rd + n_wr;
        bus_start();
        send_byte(8'hA0, ack);
        check(!ack, "R3 busy no ack", int'(ack), 0);
        send_byte(8'h00, ack);
        check(n_ld + n_rd + n_wr == base, "R3 busy no strobe", n_ld + n_rd + n_wr, base);
        bus_stop();
        busy = 1'b0;

        // R4, R5: write header and three data bytes
        strap = 3'b101;
        base = n_stop;
        bus_start();
        send_byte(8'hAA, ack);
        check(ack, "R4 write device ack", int'(ack), 1);
        send_byte(8'h12, ack);
        check(ack, "R4 high address ack", int'(ack), 1);
        send_byte(8'h34, ack);
        check(ack, "R4 low address ack", int'(ack), 1);
        check(n_ld == 1, "R4 address load count", n_ld, 1);
        check(last_addr == 13'h1234, "R4 loaded address", int'(last_addr), 'h1234);
        send_byte(8'hC3, ack);
        check(ack, "R5 data ack", int'(ack), 1);
        send_byte(8'h3C, ack);
        send_byte(8'h00, ack);
        check(n_wr == 3, "R5 write strobe count", n_wr, 3);
        check(wr_log[0] == 8'hC3 && wr_log[1] == 8'h3C && wr_log[2] == 8'h00,
              "R5 write data", int'({wr_log[0], wr_log[1], wr_log[2]}), 'hC33C00);
        bus_stop();
        check(n_stop == base + 1, "R1 stop strobe", n_stop, base + 1);

        // R7, R8: random read at 0x0035 with two acks then a no-ack
        base = n_rd;
        bus_start();
        send_byte(8'hAA, ack);
        send_byte(8'h00, ack);
        send_byte(8'h35, ack);
        bus_start();
        send_byte(8'hAB, ack);
        check(ack, "R6 read device ack", int'(ack), 1);
        recv_byte(1'b1, b);
        check(b == 8'h3C, "R7 random read first byte", int'(b), 'h3C);
        recv_byte(1'b1, b);
        check(b == 8'h00, "R8 sequential second byte", int'(b), 'h00);
        recv_byte(1'b0, b);
        check(b == (8'h37 ^ 8'h5A), "R8 sequential third byte", int'(b), int'(8'h37 ^ 8'h5A));
        check(n_rd == base + 3, "R8 request count", n_rd, base + 3);
        check(n_wr == 3, "R7 no write in random read", n_wr, 3);
        clock_bit(1'b1, r);
        check(r == 1'b1, "R8 line released after no-ack", int'(r), 1);
        bus_stop();

        // R6: current-address read continues from the memory side pointer
        bus_start();
        send_byte(8'hAB, ack);
        recv_byte(1'b0, b);
        check(b == (8'h38 ^ 8'h5A), "R6 current address read", int'(b), int'(8'h38 ^ 8'h5A));
        bus_stop();

        // R1: start in the middle of a device address restarts reception
        bus_start();
        clock_bit(1'b1, r); clock_bit(1'b0, r); clock_bit(1'b1, r); clock_bit(1'b0, r);
        bus_start();
        send_byte(8'hAA, ack);
        check(ack, "R1 start abort then ack", int'(ack), 1);
        bus_stop();

        // R1: stop in the middle of a data byte writes nothing
        base = n_wr;
        bus_start();
        send_byte(8'hAA, ack);
        send_byte(8'h00, ack);
        send_byte(8'h40, ack);
        clock_bit(1'b1, r); clock_bit(1'b1, r); clock_bit(1'b0, r);
        bus_stop();
        check(n_wr == base, "R1 stop abort no write", n_wr, base);
        check(sda_oe == 1'b0, "R1 stop releases line", int'(sda_oe), 0);

        // R9, R10: whole-run observations
        check(n_oe_hi == 0, "R9 drive change with clock high", n_oe_hi, 0);
        check(n_multi == 0, "R10 overlapping strobes", n_multi, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule